// File: doc/BRIEF.md
# Queued Conversion Request Source

This block keeps an ordered list of up to eight conversion requests for an ADC sequencer and presents them one at a time to the converter arbiter. Software appends requests through a write port. Each request names a channel and carries three control flags of its own. The refill flag recycles the entry, the trigger-wait flag makes it wait for an external trigger, and the event flag makes it emit a completion pulse. The entry at the head of the list is offered to the arbiter when its trigger condition and the gate input allow it. The block then follows a grant and conversion-done handshake, and after that it retires the entry.

An entry whose refill flag is set is appended to the tail again when its conversion completes. A set of refilling entries therefore forms a sequence that repeats without software involvement. A gate input holds back new requests but never cuts short a request already raised or a conversion already running. A flush input empties the list in one cycle. Writes that find the list full are dropped and recorded in a sticky overflow flag. The arbiter, the analog converter and result storage are outside this block.

Top module: `convq_source`

## Requirements
- R1: Entries are converted in the order they were written, and any channel value from 0 to 31 may appear in any entry, repeats included. `fill_level` gives the number of stored entries (0 to 8) and reflects a write or a retirement one clock after the edge that accepts it.
- R2: A write that would make the list exceed 8 entries is discarded. `fill_level` stays at 8 and `ovf_flag` rises one clock later and stays high until reset.
- R3: `conv_req` rises one clock after the head becomes eligible and stays high until a clock edge with `grant` high. A `conv_done` pulse is ignored unless it comes after that grant. The edge that samples the accepted `conv_done` retires the head, and `conv_chan` shows the head's channel while `conv_req` is high.
- R4: When a retired entry has its refill flag set, it is appended to the tail in the same clock, so `fill_level` is unchanged by that retirement.
- R5: A head entry whose trigger-wait flag is set does not request until a rising edge (0 to 1) is seen on `trig_in`. A rising edge seen while such an entry is waiting is remembered until the request is raised. Edges seen at any other time have no effect.
- R6: `src_event` is high for exactly one cycle, the cycle after the edge that retires an entry whose event flag is set. It stays low for entries without the flag.
- R7: While `gate_open` is low, no new request is raised. A request already raised stays high, and a granted conversion completes and retires normally.
- R8: A clock edge with `flush` high empties the list, drops any remembered trigger, abandons any request or conversion and ignores a write in that cycle. On the next cycle `fill_level` is 0 and `conv_req` is low.
- R9: When a write and a refill occur in the same clock, the refilled entry is placed ahead of the written entry. When the list is full after the retirement, the written entry is dropped.
- R10: After reset, which is synchronous and active high, `fill_level` is 0 and `conv_req`, `src_event` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Append one entry this cycle |
| wr_chan | input | 5 | Channel number of the written entry |
| wr_refill | input | 1 | Refill flag of the written entry |
| wr_trig_wait | input | 1 | Trigger-wait flag of the written entry |
| wr_evt_en | input | 1 | Event flag of the written entry |
| flush | input | 1 | Empty the list and drop pending trigger |
| trig_in | input | 1 | External trigger line, rising edge significant |
| gate_open | input | 1 | High allows new requests |
| grant | input | 1 | Arbiter accepts the raised request |
| conv_done | input | 1 | Converter finished the granted conversion |
| conv_req | output | 1 | Conversion request to the arbiter |
| conv_chan | output | 5 | Channel of the head entry |
| src_event | output | 1 | One-cycle completion event |
| ovf_flag | output | 1 | Sticky flag for dropped writes |
| fill_level | output | 4 | Number of stored entries |

## Verification
The hardest case to reach is the same-cycle collision between a refilling retirement and a software write. It needs a refill entry at the head, a granted conversion and a write placed exactly on the `conv_done` cycle, and in its full form the list must also be at capacity. A directed sequence builds the collision on a one-entry list. Random stimulus with a high refill rate keeps the list near full, so the drop case also comes up repeatedly. A trigger edge captured while the gate is closed is another narrow window. A directed sequence drives that edge with the gate low and opens the gate later. A cycle-accurate reference model in the bench compares every output on every cycle.

// File: rtl/convq_pkg.sv
package convq_pkg;

    parameter int unsigned CHAN_W  = 5;
    parameter int unsigned QDEPTH  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              refill;
        logic              trig_wait;
        logic              evt_en;
    } qent_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic qent_t make_entry(input logic [CHAN_W-1:0] ch,
                                         input logic rf, input logic tw,
                                         input logic ev);
        qent_t e;
        e.chan      = ch;
        e.refill    = rf;
        e.trig_wait = tw;
        e.evt_en    = ev;
        return e;
    endfunction

endpackage

// File: rtl/convq_store.sv
module convq_store
    import convq_pkg::*;
#(
    parameter int unsigned DEPTH = QDEPTH,
    localparam int unsigned PW = ptr_bits(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          pop,
    input  logic          push_a,
    input  qent_t         ent_a,
    input  logic          push_b,
    input  qent_t         ent_b,
    output qent_t         head,
    output logic [CW-1:0] count,
    output logic          drop_b
);

    qent_t         mem [DEPTH];
    logic [PW-1:0] hd_ptr, tl_ptr;
    logic [PW-1:0] tail_b, tl_after_a, tl_next;
    logic [CW-1:0] base_cnt;
    logic          accept_b;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        base_cnt   = count - CW'(pop) + CW'(push_a);
        accept_b   = push_b && (base_cnt < CW'(DEPTH));
        drop_b     = push_b && !accept_b;
        tl_after_a = push_a ? wrap_inc(tl_ptr) : tl_ptr;
        tail_b     = tl_after_a;
        tl_next    = accept_b ? wrap_inc(tl_after_a) : tl_after_a;
        head       = mem[hd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hd_ptr <= '0;
            tl_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) hd_ptr <= wrap_inc(hd_ptr);
            tl_ptr <= tl_next;
            count  <= base_cnt + CW'(accept_b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush) begin
            if (push_a)   mem[tl_ptr] <= ent_a;
            if (accept_b) mem[tail_b] <= ent_b;
        end
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    p_drop_when_full_r2: assert property (@(posedge clk) disable iff (rst)
        (drop_b && !flush) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/convq_trig.sv
module convq_trig (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic trig_in,
    input  logic arm,
    input  logic consume,
    output logic released
);

    logic trig_q;
    logic pend;
    logic edge_seen;

    always_comb begin
        edge_seen = trig_in && !trig_q;
        released  = pend || edge_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)          pend <= 1'b0;
        else if (consume)          pend <= 1'b0;
        else if (arm && edge_seen) pend <= 1'b1;
    end

    p_pend_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        pend |-> arm);

    p_flush_drops_pend_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pend);

endmodule

// File: rtl/convq_ctrl.sv
module convq_ctrl
    import convq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  gate_open,
    input  logic  grant,
    input  logic  conv_done,
    input  logic  head_valid,
    input  qent_t head,
    input  logic  released,
    output logic  conv_req,
    output logic  pop,
    output logic  push_refill,
    output logic  arm,
    output logic  consume,
    output logic  src_event
);

    seq_state_e state, state_nx;
    logic       ready;

    always_comb begin
        ready       = head_valid && gate_open && (!head.trig_wait || released);
        arm         = (state == ST_IDLE) && head_valid && head.trig_wait;
        consume     = (state == ST_IDLE) && ready;
        pop         = (state == ST_CONV) && conv_done && !flush;
        push_refill = pop && head.refill;
        conv_req    = (state == ST_REQ);
        state_nx    = state;
        unique case (state)
            ST_IDLE: if (ready)     state_nx = ST_REQ;
            ST_REQ:  if (grant)     state_nx = ST_CONV;
            ST_CONV: if (conv_done) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) state <= ST_IDLE;
        else              state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) src_event <= 1'b0;
        else              src_event <= pop && head.evt_en;
    end

    p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !grant && !flush) |=> conv_req);

    p_gate_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !gate_open) |=> !conv_req);

    p_trig_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (arm && !released) |=> !conv_req);

    p_event_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        src_event |=> !src_event);

endmodule

// File: rtl/convq_source.sv
module convq_source
    import convq_pkg::*;
#(
    parameter int unsigned DEPTH = QDEPTH,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_refill,
    input  logic              wr_trig_wait,
    input  logic              wr_evt_en,
    input  logic              flush,
    input  logic              trig_in,
    input  logic              gate_open,
    input  logic              grant,
    input  logic              conv_done,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              src_event,
    output logic              ovf_flag,
    output logic [CW-1:0]     fill_level
);

    qent_t         head, wr_ent;
    logic [CW-1:0] count;
    logic          pop, push_refill, drop_b;
    logic          arm, consume, released;

    assign wr_ent     = make_entry(wr_chan, wr_refill, wr_trig_wait, wr_evt_en);
    assign conv_chan  = head.chan;
    assign fill_level = count;

    convq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .pop    (pop),
        .push_a (push_refill),
        .ent_a  (head),
        .push_b (wr_en),
        .ent_b  (wr_ent),
        .head   (head),
        .count  (count),
        .drop_b (drop_b)
    );

    convq_trig u_trig (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .trig_in  (trig_in),
        .arm      (arm),
        .consume  (consume),
        .released (released)
    );

    convq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .gate_open   (gate_open),
        .grant       (grant),
        .conv_done   (conv_done),
        .head_valid  (count != '0),
        .head        (head),
        .released    (released),
        .conv_req    (conv_req),
        .pop         (pop),
        .push_refill (push_refill),
        .arm         (arm),
        .consume     (consume),
        .src_event   (src_event)
    );

    always_ff @(posedge clk) begin
        if (rst)         ovf_flag <= 1'b0;
        else if (drop_b && !flush) ovf_flag <= 1'b1;
    end

    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_level == '0 && !conv_req));

    p_refill_keeps_level_r4: assert property (@(posedge clk) disable iff (rst)
        (push_refill && !wr_en && !flush) |=> (fill_level == $past(fill_level)));

endmodule

// File: tb/convq_source_test.sv
module convq_source_test;

    logic       clk = 1'b0;
    logic       rst, wr_en, wr_refill, wr_trig_wait, wr_evt_en;
    logic [4:0] wr_chan;
    logic       flush, trig_in, gate_open, grant, conv_done;
    logic       conv_req, src_event, ovf_flag;
    logic [4:0] conv_chan;
    logic [3:0] fill_level;

    always #10 clk = ~clk;  // 50 MHz

    convq_source uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_refill(wr_refill), .wr_trig_wait(wr_trig_wait), .wr_evt_en(wr_evt_en),
        .flush(flush), .trig_in(trig_in), .gate_open(gate_open), .grant(grant),
        .conv_done(conv_done), .conv_req(conv_req), .conv_chan(conv_chan),
        .src_event(src_event), .ovf_flag(ovf_flag), .fill_level(fill_level)
    );

    // stimulus for the next clock edge
    bit s_rst, s_wr, s_rf, s_tw, s_ev, s_flush, s_trig, s_gate, s_grant, s_done;
    int s_ch;

    // reference model
    typedef struct {int ch; bit rf; bit tw; bit ev;} ment_t;
    ment_t mq[$];
    int    m_st;
    bit    m_pend, m_prev, m_ovf, m_evt, started;
    int    nchk, nfail, cyc;

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    function automatic void model_step();
        bit   edge_s, ready;
        ment_t e;
        if (s_rst) begin
            mq.delete(); m_st = 0; m_pend = 0; m_prev = 0; m_ovf = 0; m_evt = 0;
            return;
        end
        if (s_flush) begin
            mq.delete(); m_st = 0; m_pend = 0; m_evt = 0; m_prev = s_trig;
            return;
        end
        edge_s = s_trig && !m_prev;
        m_prev = s_trig;
        m_evt  = 0;
        case (m_st)
            0: if (mq.size() > 0) begin
                ready = s_gate && (!mq[0].tw || m_pend || edge_s);
                if (ready) begin m_st = 1; m_pend = 0; end
                else if (mq[0].tw && edge_s) m_pend = 1;
            end
            1: if (s_grant) m_st = 2;
            default: if (s_done) begin
                e = mq.pop_front();
                m_evt = e.ev;
                if (e.rf) mq.push_back(e);
                m_st = 0;
            end
        endcase
        if (s_wr) begin
            if (mq.size() < 8) begin
                e.ch = s_ch; e.rf = s_rf; e.tw = s_tw; e.ev = s_ev;
                mq.push_back(e);
            end else m_ovf = 1;
        end
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (started) begin
            check("R3", "conv_req", conv_req, m_st == 1);
            if (m_st == 1 && mq.size() > 0) check("R1", "conv_chan", conv_chan, mq[0].ch);
            check("R1", "fill_level", fill_level, mq.size());
            check("R2", "ovf_flag", ovf_flag, m_ovf);
            check("R6", "src_event", src_event, m_evt);
        end
        started = 1;
        rst = s_rst; wr_en = s_wr; wr_chan = 5'(s_ch); wr_refill = s_rf;
        wr_trig_wait = s_tw; wr_evt_en = s_ev; flush = s_flush; trig_in = s_trig;
        gate_open = s_gate; grant = s_grant; conv_done = s_done;
        model_step();
    endtask

    task automatic write(input int ch, input bit rf, input bit tw, input bit ev);
        s_wr = 1; s_ch = ch; s_rf = rf; s_tw = tw; s_ev = ev;
        tick();
        s_wr = 0; s_rf = 0; s_tw = 0; s_ev = 0;
    endtask

    // converter stub: wait for request, grant, then finish one cycle later
    task automatic serve_one(output int ch);
        int guard = 0;
        while (!conv_req && guard < 40) begin tick(); guard++; end
        check("R3", "request seen", conv_req, 1);
        ch = conv_chan;
        s_grant = 1; tick(); s_grant = 0;
        s_done = 1;  tick(); s_done = 0;
    endtask

    task automatic do_flush();
        s_flush = 1; tick(); s_flush = 0; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int ch;
        int exp_order[8] = '{3, 7, 7, 1, 30, 0, 7, 12};
        void'($urandom(32'd20240611));
        {s_wr, s_rf, s_tw, s_ev, s_flush, s_trig, s_grant, s_done} = '0;
        s_ch = 0; s_gate = 1; s_rst = 1;
        repeat (3) tick();
        s_rst = 0; tick(); tick();
        // R10 reset state
        check("R10", "fill after reset", fill_level, 0);
        check("R10", "req after reset", conv_req, 0);
        check("R10", "ovf after reset", ovf_flag, 0);
        check("R10", "event after reset", src_event, 0);

        // R2 overflow, R1 order with repeats
        s_gate = 0;
        foreach (exp_order[i]) write(exp_order[i], 0, 0, 0);
        write(21, 0, 0, 0);
        tick();
        check("R2", "fill when full", fill_level, 8);
        check("R2", "ovf after drop", ovf_flag, 1);
        s_gate = 1;
        foreach (exp_order[i]) begin
            serve_one(ch);
            check("R1", "fifo order", ch, exp_order[i]);
        end
        tick();
        check("R1", "fill after drain", fill_level, 0);

        // R4 refill
        s_gate = 0;
        write(5, 1, 0, 0);
        write(9, 0, 0, 0);
        s_gate = 1;
        serve_one(ch); check("R4", "first conv", ch, 5);
        tick();
        check("R4", "fill unchanged by refill", fill_level, 2);
        serve_one(ch); check("R4", "second conv", ch, 9);
        serve_one(ch); check("R4", "refilled conv", ch, 5);
        tick();
        check("R4", "refill entry remains", fill_level, 1);
        // R8 flush while requesting
        do_flush();
        check("R8", "fill after flush", fill_level, 0);
        check("R8", "req after flush", conv_req, 0);

        // R5 trigger wait, R6 event
        s_gate = 1; s_trig = 0;
        write(12, 0, 1, 1);
        for (int i = 0; i < 6; i++) begin
            tick();
            check("R5", "no request before edge", conv_req, 0);
        end
        s_trig = 1; tick();
        tick();
        check("R5", "request after edge", conv_req, 1);
        s_trig = 0;
        serve_one(ch); check("R5", "triggered channel", ch, 12);
        tick(); check("R6", "event pulse", src_event, 1);
        tick(); check("R6", "event one cycle", src_event, 0);

        // R5 edge captured while gate closed
        s_gate = 0;
        write(8, 0, 1, 0);
        s_trig = 1; tick(); s_trig = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R7", "gate holds captured trigger", conv_req, 0);
        end
        s_gate = 1; tick(); tick();
        check("R5", "captured edge releases", conv_req, 1);
        serve_one(ch);
        tick(); check("R6", "no event without flag", src_event, 0);

        // R7 gate
        s_gate = 0;
        write(2, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R7", "no request while gated", conv_req, 0);
        end
        s_gate = 1; tick(); tick();
        check("R7", "request after gate opens", conv_req, 1);
        s_gate = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R7", "raised request held", conv_req, 1);
        end
        s_done = 1; tick(); s_done = 0;  // stray done before grant
        tick();
        check("R3", "done before grant ignored", fill_level, 1);
        s_grant = 1; tick(); s_grant = 0;
        s_done = 1; tick(); s_done = 0;
        tick();
        check("R7", "gated conversion completes", fill_level, 0);

        // R9 refill and write in the same cycle
        s_gate = 0;
        write(4, 1, 0, 0);
        s_gate = 1;
        while (!conv_req) tick();
        s_grant = 1; tick(); s_grant = 0;
        s_done = 1; s_wr = 1; s_ch = 6; tick();
        s_done = 0; s_wr = 0;
        tick();
        check("R9", "both entries stored", fill_level, 2);
        serve_one(ch); check("R9", "refill ahead of write", ch, 4);
        serve_one(ch); check("R9", "written entry second", ch, 6);
        do_flush();

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            s_wr    = ($urandom % 100) < 25;
            s_ch    = $urandom % 32;
            s_rf    = ($urandom % 100) < 40;
            s_tw    = ($urandom % 100) < 25;
            s_ev    = ($urandom % 2) == 1;
            if (($urandom % 100) < 30) s_trig = !s_trig;
            s_gate  = ($urandom % 100) < 85;
            s_grant = conv_req && (($urandom % 2) == 1);
            s_done  = (m_st == 2) ? (($urandom % 100) < 40) : (($urandom % 100) < 3);
            s_flush = ($urandom % 1000) < 5;
            tick();
        end
        {s_wr, s_grant, s_done, s_trig} = '0;
        do_flush();
        check("R8", "final flush", fill_level, 0);
        report();
        $finish;
    end

endmodule